// File: doc/BRIEF.md
# FIFO Status and Interrupt Unit

This unit sits beside a transmit FIFO and a receive FIFO of a serial controller and turns their condition into software-visible state. From the FIFOs it takes the fill levels, the full and empty flags, and the push and pop strobes. From the shift engine it takes a busy level. From these it builds a status word, a five-source interrupt vector and a single interrupt line.

Two of the interrupt sources are level conditions. One compares the transmit level against a programmable low-water threshold. The other compares the receive level against a programmable high-water threshold. The other three sources are sticky error flags: transmit overflow, receive overflow and receive underflow. Each error flag stays set until software writes a one to the matching bit of a clear register. Each error has its own clear bit, and one further bit clears every error at once.

The threshold registers keep only values below the FIFO depth. A driver can therefore discover the depth by writing rising values from 2 and stopping at the first value that does not read back. Register access is a plain single-cycle write strobe with address and data. Read data is a combinational decode of the address. There is no back-pressure on this port, and every access completes in the cycle it is presented.

Top module: `fifo_irq_status`

## Requirements
- R1: The status word (address 0) holds busy in bit 0, TX full in bit 1, TX empty in bit 2, RX empty in bit 3 and RX full in bit 4. Each bit follows its input directly.
- R2: Raw interrupt vector (address 1) bit 0 is 1 while tx_level is at or below the TX threshold. Bit 4 is 1 while rx_level is above the RX threshold. Neither bit is sticky.
- R3: Raw bit 1 (TX overflow) sets in the cycle after a tx_push while tx_full is high. It then stays set until it is cleared.
- R4: Raw bit 3 (RX overflow) sets in the cycle after an rx_push while rx_full is high. It is sticky.
- R5: Raw bit 2 (RX underflow) sets in the cycle after an rx_pop while rx_empty is high. It is sticky.
- R6: A write to the clear register (address 4) acts on the written bits as follows: bit 0 clears all three error flags, bit 1 clears RX underflow, bit 2 clears RX overflow, and bit 3 clears TX overflow. If an error event and its clear arrive in the same cycle, the flag stays set.
- R7: The TX threshold (address 5) and RX threshold (address 6) reset to 0. A write of a value below DEPTH is stored. A write of a value of DEPTH or more is ignored, and the old value stays.
- R8: The mask register (address 2) resets to 0 and can be read back. The masked vector (address 3) is the raw vector ANDed with the mask.
- R9: irq is high exactly when at least one bit of the masked vector is 1.
- R10: Address 7 reads tx_level and address 8 reads rx_level, zero-extended. All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| busy | input | 1 | Shift engine active |
| tx_full | input | 1 | TX FIFO full |
| tx_empty | input | 1 | TX FIFO empty |
| rx_full | input | 1 | RX FIFO full |
| rx_empty | input | 1 | RX FIFO empty |
| tx_level | input | clog2(DEPTH+1) | TX FIFO entry count |
| rx_level | input | clog2(DEPTH+1) | RX FIFO entry count |
| tx_push | input | 1 | Write into TX FIFO |
| rx_push | input | 1 | Engine delivers a frame to RX FIFO |
| rx_pop | input | 1 | Read of the RX data port |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with DEPTH=8 and DW=32. With these values the threshold registers are three bits wide, and the level inputs are four bits wide so that they can reach 8. The depth probe can therefore be tested to its end: 7 is accepted and 8 is refused. The bench also drives levels at, just below and just above each threshold. It walks the sticky flags through every individual clear and through the clear-all, and it covers the case where an event and its clear arrive together.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam logic [3:0] A_STATUS = 4'd0;
  localparam logic [3:0] A_RAW    = 4'd1;
  localparam logic [3:0] A_MASK   = 4'd2;
  localparam logic [3:0] A_MSKD   = 4'd3;
  localparam logic [3:0] A_CLEAR  = 4'd4;
  localparam logic [3:0] A_TXTHR  = 4'd5;
  localparam logic [3:0] A_RXTHR  = 4'd6;
  localparam logic [3:0] A_TXLVL  = 4'd7;
  localparam logic [3:0] A_RXLVL  = 4'd8;

  localparam int NSRC  = 5;
  localparam int NERR  = 3;
  localparam int NTHR  = 2;

  localparam int IV_TXLOW  = 0;
  localparam int IV_TXOVF  = 1;
  localparam int IV_RXUDF  = 2;
  localparam int IV_RXOVF  = 3;
  localparam int IV_RXHIGH = 4;

  localparam int CL_ALL   = 0;
  localparam int CL_RXUDF = 1;
  localparam int CL_RXOVF = 2;
  localparam int CL_TXOVF = 3;
endpackage

// File: rtl/fis_thresh.sv
module fis_thresh #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [TW-1:0] thr
);
  logic fits;
  assign fits = (wdata < DW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thr <= '0;
    else if (we && fits) thr <= wdata[TW-1:0];
  end
endmodule

// File: rtl/fis_sticky.sv
module fis_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~clr);
  end
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fis_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int TW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          tx_full,
  input  logic          tx_empty,
  input  logic          rx_full,
  input  logic          rx_empty,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          tx_push,
  input  logic          rx_push,
  input  logic          rx_pop,
  output logic          irq
);
  logic [NSRC-1:0] status_w;
  logic [NSRC-1:0] raw_w;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] mskd_w;
  logic [3:0]      clr_v;
  logic [TW-1:0]   thr_q [NTHR];
  logic [NTHR-1:0] thr_we;
  logic [NERR-1:0] err_set, err_clr, err_q;
  logic [TW-1:0]   tx_thr, rx_thr;

  assign clr_v     = (reg_wr && reg_addr == A_CLEAR) ? reg_wdata[3:0] : 4'b0;
  assign thr_we[0] = reg_wr && reg_addr == A_TXTHR;
  assign thr_we[1] = reg_wr && reg_addr == A_RXTHR;

  genvar gi;
  generate
    for (gi = 0; gi < NTHR; gi++) begin : g_thr
      fis_thresh #(.DEPTH(DEPTH), .DW(DW)) u_thr (
        .clk(clk), .rst_n(rst_n), .we(thr_we[gi]),
        .wdata(reg_wdata), .thr(thr_q[gi])
      );
    end
  endgenerate

  assign tx_thr = thr_q[0];
  assign rx_thr = thr_q[1];

  // error slots: 0 tx overflow, 1 rx underflow, 2 rx overflow
  assign err_set[0] = tx_push && tx_full;
  assign err_set[1] = rx_pop && rx_empty;
  assign err_set[2] = rx_push && rx_full;
  assign err_clr[0] = clr_v[CL_ALL] | clr_v[CL_TXOVF];
  assign err_clr[1] = clr_v[CL_ALL] | clr_v[CL_RXUDF];
  assign err_clr[2] = clr_v[CL_ALL] | clr_v[CL_RXOVF];

  generate
    for (gi = 0; gi < NERR; gi++) begin : g_err
      fis_sticky u_flag (
        .clk(clk), .rst_n(rst_n), .set(err_set[gi]),
        .clr(err_clr[gi]), .flag(err_q[gi])
      );
    end
  endgenerate

  assign status_w = {rx_full, rx_empty, tx_empty, tx_full, busy};

  always_comb begin
    raw_w            = '0;
    raw_w[IV_TXLOW]  = (tx_level <= LW'(tx_thr));
    raw_w[IV_TXOVF]  = err_q[0];
    raw_w[IV_RXUDF]  = err_q[1];
    raw_w[IV_RXOVF]  = err_q[2];
    raw_w[IV_RXHIGH] = (rx_level > LW'(rx_thr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[NSRC-1:0];
  end

  assign mskd_w = raw_w & mask_q;
  assign irq    = |mskd_w;

  always_comb begin
    case (reg_addr)
      A_STATUS: reg_rdata = DW'(status_w);
      A_RAW:    reg_rdata = DW'(raw_w);
      A_MASK:   reg_rdata = DW'(mask_q);
      A_MSKD:   reg_rdata = DW'(mskd_w);
      A_TXTHR:  reg_rdata = DW'(tx_thr);
      A_RXTHR:  reg_rdata = DW'(rx_thr);
      A_TXLVL:  reg_rdata = DW'(tx_level);
      A_RXLVL:  reg_rdata = DW'(rx_level);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fis_checker.sv
module fis_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_push,
  input logic       tx_full,
  input logic       rx_push,
  input logic       rx_full,
  input logic       rx_pop,
  input logic       rx_empty,
  input logic [3:0] clr_v,
  input logic [4:0] raw,
  input logic [4:0] mask,
  input logic       irq
);
  a_r3_txovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full) |=> raw[1]);
  a_r3_txovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[1] && !clr_v[0] && !clr_v[3]) |=> raw[1]);
  a_r4_rxovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> raw[3]);
  a_r5_rxudf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |=> raw[2]);
  a_r6_txovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v[3] && !(tx_push && tx_full)) |=> !raw[1]);
  a_r6_all_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v[0] && !(rx_push && rx_full)) |=> !raw[3]);
  a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != 5'b0));
endmodule

bind fifo_irq_status fis_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_full(tx_full),
  .rx_push(rx_push), .rx_full(rx_full), .rx_pop(rx_pop), .rx_empty(rx_empty),
  .clr_v(clr_v), .raw(raw_w), .mask(mask_q), .irq(irq)
);

// File: tb/fifo_irq_status_tb.sv
module fifo_irq_status_tb;
  localparam int DEPTH = 8;
  localparam int DW    = 32;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic busy = 0, tx_full = 0, tx_empty = 1, rx_full = 0, rx_empty = 1;
  logic [LW-1:0] tx_level = 0, rx_level = 0;
  logic tx_push = 0, rx_push = 0, rx_pop = 0;
  logic irq;
  logic rd_stb = 0;
  logic done = 0;

  int errors = 0, checks = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  fifo_irq_status #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full),
    .rx_empty(rx_empty), .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop), .irq(irq)
  );

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (rd_stb && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %0h expected %0h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [DW-1:0] e, input string t);
    reg_addr = a; rd_stb = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_stb = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", t, irq, e);
    end
    @(posedge clk); #1;
  endtask

  task automatic tick;
    @(posedge clk); #1;
    tx_push = 0; rx_push = 0; rx_pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    // reset state
    rd(4'd0, 32'h0C, "R1 status after reset");
    rd(4'd2, 32'h00, "R8 mask reset");
    rd(4'd5, 32'h00, "R7 tx threshold reset");
    rd(4'd6, 32'h00, "R7 rx threshold reset");
    rd(4'd1, 32'h01, "R2 raw after reset");
    chk_irq(1'b0, "R9 irq after reset");
    // status mapping
    busy = 1; tx_full = 1; tx_empty = 0; rx_empty = 0; rx_full = 1;
    rd(4'd0, 32'h13, "R1 status pattern a");
    busy = 0; tx_full = 0; tx_empty = 1; rx_empty = 0; rx_full = 0;
    rd(4'd0, 32'h04, "R1 status pattern b");
    // levels
    tx_level = 5; rx_level = 3;
    rd(4'd7, 32'd5, "R10 tx level");
    rd(4'd8, 32'd3, "R10 rx level");
    rd(4'd9, 32'd0, "R10 unused address");
    // thresholds and depth probe
    wr(4'd5, 32'd5);  rd(4'd5, 32'd5, "R7 tx thr accept 5");
    wr(4'd5, 32'd8);  rd(4'd5, 32'd5, "R7 tx thr reject depth");
    wr(4'd5, 32'd7);  rd(4'd5, 32'd7, "R7 tx thr accept depth-1");
    wr(4'd6, 32'd100); rd(4'd6, 32'd0, "R7 rx thr reject large");
    wr(4'd6, 32'd3);  rd(4'd6, 32'd3, "R7 rx thr accept 3");
    // level comparisons: tx 5<=7, rx 3>3 false
    rd(4'd1, 32'h01, "R2 tx below, rx at thr");
    rx_level = 4;
    rd(4'd1, 32'h11, "R2 rx above thr");
    tx_level = 7;
    rd(4'd1, 32'h11, "R2 tx at thr");
    tx_level = 8; rx_level = 0;
    rd(4'd1, 32'h00, "R2 tx above thr, not sticky");
    // tx overflow
    tx_push = 1; tick;
    rd(4'd1, 32'h00, "R3 push not full no effect");
    tx_push = 1; tx_full = 1; tick; tx_full = 0;
    rd(4'd1, 32'h02, "R3 tx overflow set");
    rd(4'd1, 32'h02, "R3 tx overflow sticky");
    // rx underflow then overflow
    rx_empty = 1; rx_pop = 1; tick;
    rd(4'd1, 32'h06, "R5 rx underflow set");
    rx_empty = 0; rx_full = 1; rx_push = 1; tick; rx_full = 0;
    rd(4'd1, 32'h0E, "R4 rx overflow set");
    // individual clears
    wr(4'd4, 32'h4); rd(4'd1, 32'h06, "R6 clear rx overflow only");
    wr(4'd4, 32'h8); rd(4'd1, 32'h04, "R6 clear tx overflow only");
    wr(4'd4, 32'h2); rd(4'd1, 32'h00, "R6 clear rx underflow only");
    // clear all
    tx_full = 1; tx_push = 1; tick;
    rx_full = 1; rx_push = 1; tick; rx_full = 0; tx_full = 0;
    rd(4'd1, 32'h0A, "R6 two errors before clear all");
    wr(4'd4, 32'h1); rd(4'd1, 32'h00, "R6 clear all");
    // event and clear in same cycle
    tx_full = 1; tx_push = 1; wr(4'd4, 32'h8); tx_push = 0; tx_full = 0;
    rd(4'd1, 32'h02, "R6 set wins over clear");
    // masking
    tx_level = 0;
    rd(4'd1, 32'h03, "R2 raw before masking");
    wr(4'd2, 32'h02);
    rd(4'd2, 32'h02, "R8 mask readback");
    rd(4'd3, 32'h02, "R8 masked vector");
    chk_irq(1'b1, "R9 irq with enabled source");
    wr(4'd2, 32'h10);
    rd(4'd3, 32'h00, "R8 masked vector disabled");
    chk_irq(1'b0, "R9 irq masked off");
    wr(4'd2, 32'h02); wr(4'd4, 32'h1);
    rd(4'd3, 32'h00, "R8 masked after clear");
    chk_irq(1'b0, "R9 irq after clear");
    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule